// File: doc/BRIEF.md
# Memory Range Scanner

The scanner walks a window of a word-addressed nonvolatile memory, from a low pointer up to and including a high pointer. For each word it issues one read and hands the fetched word to a downstream checksum client, such as a CRC engine, over a ready/valid handshake. Software programs the two pointers and a control register through a small write port and reads them back at all times. The control register holds an enable, a go request, the interrupt-management option and a two-bit arbitration mode. Busy and invalid are status bits that the hardware maintains.

The arbitration mode sets when the scanner may take the memory. Concurrent mode reads whenever the client is ready. Burst mode also holds the CPU in a stall for the whole scan. Peek mode reads only on cycles the CPU marks as idle. Triggered mode reads only on an external trigger pulse. An interrupt can hide the go request without erasing it, so the scan picks up where it stopped once service ends. Reads that run past the mapped memory, or that wrap the pointer, stop the scan and raise the invalid flag.

Top module: `mem_range_scanner`

## Requirements
- R1: After reset the control readback is 0x00, both pointers read 0, and mem_rd_o, clt_valid_o and cpu_stall_o are low.
- R2: Register selects are 0 control, 1 low pointer, 2 high pointer; select 3 writes nothing. Control readback bits: 7 enable, 6 go, 5 busy, 4 invalid, 3 interrupt management, 2 reads 0, 1:0 mode.
- R3: A transfer starts in a cycle where the scanner is enabled, go is in effect, low <= high, clt_ready_i is 1 and the mode permits it. In the next cycle mem_rd_o is high for one cycle with mem_addr_o equal to the low pointer. Two cycles after that read cycle, clt_valid_o is high for one cycle carrying the word returned by the memory, and the low pointer then advances by one. Words arrive in address order.
- R4: When no transfer is in flight and the low pointer exceeds the high pointer, go returns to 0 on its own.
- R5: Busy reads 1 while a transfer is in flight, or while enable, go and clt_ready_i are all 1. Otherwise it reads 0.
- R6: A go request (writing 1 while go is 0) is refused when clt_en_i or clt_go_i is 0, or when the low pointer is unmapped. A refused request leaves go at 0, sets invalid, and starts no read. An accepted request sets go and clears invalid.
- R7: If advancing the low pointer wraps it or lands on an unmapped address (at or above MAP_WORDS, 240 by default), invalid sets and go clears.
- R8: Clearing enable abandons any transfer in flight without a valid word and returns the state machine to idle. The pointers and the other control bits are unchanged.
- R9: In burst mode (01), cpu_stall_o is high while go is in effect. In concurrent (00) and triggered (11) modes it is high exactly on read cycles. In peek mode (10) it stays low.
- R10: With interrupt management at 1 in modes 00, 01 or 11, an active interrupt keeps go from taking effect: no new transfer starts and no burst stall is held. The stored go bit stays 1, and scanning resumes when the interrupt ends.
- R11: With interrupt management at 0, or in peek mode whatever its value, an active interrupt does not hold back transfers.
- R12: Peek mode starts transfers only in cycles with cpu_idle_i high. Triggered mode starts one transfer per cycle in which trig_i is high.
- R13: A write to the low pointer in the same cycle as a completing transfer takes priority over the pointer increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | ADDR_W | Write data (control uses bits 7:0) |
| ctrl_o | output | 8 | Control/status readback |
| lo_o | output | ADDR_W | Low pointer readback |
| hi_o | output | ADDR_W | High pointer readback |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory word, valid the cycle after the strobe |
| clt_en_i | input | 1 | Client enabled |
| clt_go_i | input | 1 | Client armed |
| clt_ready_i | input | 1 | Client ready for a word |
| clt_valid_o | output | 1 | Word valid to client |
| clt_data_o | output | DATA_W | Word to client |
| irq_active_i | input | 1 | CPU servicing an interrupt |
| cpu_idle_i | input | 1 | CPU leaves memory idle this cycle |
| trig_i | input | 1 | External trigger pulse |
| cpu_stall_o | output | 1 | Stall request to the CPU |

## Verification
The two functions that can fall in one cycle are the pointer increment at the end of a transfer and a software write to the low pointer. To provoke this, the bench watches for clt_valid_o and, in that same cycle, presents a low-pointer write while dropping ready. It then judges the outcome from the readback: the low pointer must hold the written value rather than the increment, and since that value lies above the high pointer, go must clear with no second word delivered.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        MODE_CONC  = 2'b00,
        MODE_BURST = 2'b01,
        MODE_PEEK  = 2'b10,
        MODE_TRIG  = 2'b11
    } scan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPT,
        ST_SEND
    } scan_st_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_LO   = 2'd1;
    localparam logic [1:0] SEL_HI   = 2'd2;

    localparam int CTL_EN   = 7;
    localparam int CTL_GO   = 6;
    localparam int CTL_INTM = 3;
endpackage

// File: rtl/scan_addr_chk.sv
module scan_addr_chk #(
    parameter int ADDR_W    = 8,
    parameter int MAP_WORDS = 240
) (
    input  logic [ADDR_W-1:0] cur_i,
    output logic [ADDR_W-1:0] next_o,
    output logic              wrap_o,
    output logic              cur_unmapped_o,
    output logic              next_unmapped_o
);
    localparam logic [ADDR_W:0] ONE = (ADDR_W+1)'(1);

    assign {wrap_o, next_o} = {1'b0, cur_i} + ONE;

    generate
        if (MAP_WORDS >= (1 << ADDR_W)) begin : g_full_map
            assign cur_unmapped_o  = 1'b0;
            assign next_unmapped_o = 1'b0;
        end else begin : g_part_map
            localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MAP_WORDS);
            assign cur_unmapped_o  = ({1'b0, cur_i} >= LIMIT);
            assign next_unmapped_o = ({1'b0, next_o} >= LIMIT);
        end
    endgenerate
endmodule

// File: rtl/scan_gate.sv
module scan_gate import scan_pkg::*; (
    input  logic       en_i,
    input  logic       go_i,
    input  logic       intm_i,
    input  scan_mode_e mode_i,
    input  logic       irq_i,
    input  logic       cpu_idle_i,
    input  logic       trig_i,
    input  logic       ready_i,
    input  logic       in_range_i,
    input  logic       fsm_idle_i,
    input  logic       mem_rd_i,
    output logic       go_eff_o,
    output logic       start_o,
    output logic       stall_o
);
    logic irq_mask;
    logic slot_ok;

    always_comb begin
        // interrupt hides go, except in peek mode where the option is ignored
        irq_mask = intm_i && irq_i && (mode_i != MODE_PEEK);
        go_eff_o = en_i && go_i && !irq_mask;
        case (mode_i)
            MODE_CONC, MODE_BURST: slot_ok = 1'b1;
            MODE_PEEK:             slot_ok = cpu_idle_i;
            default:               slot_ok = trig_i;
        endcase
        start_o = go_eff_o && fsm_idle_i && in_range_i && ready_i && slot_ok;
        stall_o = (go_eff_o && (mode_i == MODE_BURST)) ||
                  (mem_rd_i && (mode_i != MODE_PEEK));
    end
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm import scan_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_rd_o,
    output logic              clt_valid_o,
    output logic [DATA_W-1:0] clt_data_o,
    output logic              done_o,
    output logic              idle_o,
    output logic              busy_o
);
    typedef struct packed {
        scan_st_e          st;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        case (f_q.st)
            ST_IDLE: if (start_i) f_d.st = ST_READ;
            ST_READ: f_d.st = ST_CAPT;
            ST_CAPT: begin
                f_d.data = mem_rdata_i;
                f_d.st   = ST_SEND;
            end
            default: f_d.st = ST_IDLE;
        endcase
        if (!en_i) f_d.st = ST_IDLE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    assign mem_rd_o    = (f_q.st == ST_READ);
    assign clt_valid_o = (f_q.st == ST_SEND) && en_i;
    assign done_o      = clt_valid_o;
    assign clt_data_o  = f_q.data;
    assign idle_o      = (f_q.st == ST_IDLE);
    assign busy_o      = !idle_o;

    a_r3_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_o |=> !mem_rd_o);
    a_r3_valid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clt_valid_o |-> $past(mem_rd_o, 2));
    a_r8_disable_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !busy_o);
endmodule

// File: rtl/mem_range_scanner.sv
module mem_range_scanner import scan_pkg::*; #(
    parameter int ADDR_W    = 8,   // at least 8: control uses wr_data_i[7:0]
    parameter int DATA_W    = 16,
    parameter int MAP_WORDS = 240
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [7:0]        ctrl_o,
    output logic [ADDR_W-1:0] lo_o,
    output logic [ADDR_W-1:0] hi_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              clt_en_i,
    input  logic              clt_go_i,
    input  logic              clt_ready_i,
    output logic              clt_valid_o,
    output logic [DATA_W-1:0] clt_data_o,
    input  logic              irq_active_i,
    input  logic              cpu_idle_i,
    input  logic              trig_i,
    output logic              cpu_stall_o
);
    typedef struct packed {
        logic              en;
        logic              go;
        logic              intm;
        logic              inv;
        scan_mode_e        mode;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] nxt_lo;
    logic wrap, nxt_unmap, cur_unmap;
    logic go_eff, start, fsm_idle, fsm_busy, done;
    logic lo_gt_hi, ctrl_wr, busy;

    assign lo_gt_hi = (r_q.lo > r_q.hi);
    assign ctrl_wr  = wr_en_i && (wr_sel_i == SEL_CTRL);

    scan_addr_chk #(.ADDR_W(ADDR_W), .MAP_WORDS(MAP_WORDS)) u_addr (
        .cur_i           (r_q.lo),
        .next_o          (nxt_lo),
        .wrap_o          (wrap),
        .cur_unmapped_o  (cur_unmap),
        .next_unmapped_o (nxt_unmap)
    );

    scan_gate u_gate (
        .en_i       (r_q.en),
        .go_i       (r_q.go),
        .intm_i     (r_q.intm),
        .mode_i     (r_q.mode),
        .irq_i      (irq_active_i),
        .cpu_idle_i (cpu_idle_i),
        .trig_i     (trig_i),
        .ready_i    (clt_ready_i),
        .in_range_i (!lo_gt_hi),
        .fsm_idle_i (fsm_idle),
        .mem_rd_i   (mem_rd_o),
        .go_eff_o   (go_eff),
        .start_o    (start),
        .stall_o    (cpu_stall_o)
    );

    scan_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (r_q.en),
        .start_i     (start),
        .mem_rdata_i (mem_rdata_i),
        .mem_rd_o    (mem_rd_o),
        .clt_valid_o (clt_valid_o),
        .clt_data_o  (clt_data_o),
        .done_o      (done),
        .idle_o      (fsm_idle),
        .busy_o      (fsm_busy)
    );

    always_comb begin
        r_d = r_q;
        // pointer advance after a delivered word
        if (done) begin
            r_d.lo = nxt_lo;
            if (wrap || nxt_unmap) begin
                r_d.inv = 1'b1;
                r_d.go  = 1'b0;
            end
        end
        // range exhausted, nothing in flight
        if (r_q.en && r_q.go && fsm_idle && lo_gt_hi) r_d.go = 1'b0;
        // software writes take priority
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_CTRL: begin
                    r_d.en   = wr_data_i[CTL_EN];
                    r_d.intm = wr_data_i[CTL_INTM];
                    r_d.mode = scan_mode_e'(wr_data_i[1:0]);
                    if (!wr_data_i[CTL_GO]) begin
                        r_d.go = 1'b0;
                    end else if (!r_q.go) begin
                        if (clt_en_i && clt_go_i && !cur_unmap) begin
                            r_d.go  = 1'b1;
                            r_d.inv = 1'b0;
                        end else begin
                            r_d.inv = 1'b1;
                        end
                    end
                end
                SEL_LO:  r_d.lo = wr_data_i;
                SEL_HI:  r_d.hi = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign busy       = fsm_busy || (r_q.en && r_q.go && clt_ready_i);
    assign ctrl_o     = {r_q.en, r_q.go, busy, r_q.inv, r_q.intm, 1'b0, r_q.mode};
    assign lo_o       = r_q.lo;
    assign hi_o       = r_q.hi;
    assign mem_addr_o = r_q.lo;

    a_r4_go_selfclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.en && r_q.go && fsm_idle && lo_gt_hi && !ctrl_wr) |=> !ctrl_o[6]);
    a_r5_busy_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_o |-> ctrl_o[5]);
    a_r7_stop_on_bad_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done && (wrap || nxt_unmap) && !ctrl_wr) |=> (ctrl_o[4] && !ctrl_o[6]));
    a_r10_irq_blocks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_rd_o && $past(r_q.intm) && ($past(r_q.mode) != MODE_PEEK)) |-> !$past(irq_active_i));
    a_r10_go_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.go && r_q.intm && irq_active_i && (r_q.mode != MODE_PEEK) &&
         !wr_en_i && !done && !lo_gt_hi) |=> ctrl_o[6]);
    a_r12_peek_uses_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_rd_o && (r_q.mode == MODE_PEEK) && ($past(r_q.mode) == MODE_PEEK)) |-> $past(cpu_idle_i));
    a_r9_peek_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.mode == MODE_PEEK) |-> !cpu_stall_o);
endmodule

// File: tb/mem_range_scanner_tb_top.sv
`timescale 1ns/1ps
module mem_range_scanner_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [AW-1:0] wr_data = '0;
    logic [7:0] ctrl;
    logic [AW-1:0] lo, hi, mem_addr;
    logic mem_rd;
    logic [DW-1:0] mem_rdata = '0;
    logic clt_en = 1'b1, clt_go = 1'b1, ready = 1'b0;
    logic clt_valid;
    logic [DW-1:0] clt_data;
    logic irq = 1'b0, cpu_idle = 1'b0, trig = 1'b0;
    logic stall;

    int errors = 0;
    int checks = 0;
    int got_n = 0, rd_n = 0, stall_n = 0, busy_bad = 0;
    logic [DW-1:0] got [0:63];

    always #2.5 clk = ~clk;

    mem_range_scanner #(.ADDR_W(AW), .DATA_W(DW), .MAP_WORDS(240)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .ctrl_o(ctrl), .lo_o(lo), .hi_o(hi),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .clt_en_i(clt_en), .clt_go_i(clt_go), .clt_ready_i(ready),
        .clt_valid_o(clt_valid), .clt_data_o(clt_data),
        .irq_active_i(irq), .cpu_idle_i(cpu_idle), .trig_i(trig),
        .cpu_stall_o(stall)
    );

    // memory model: word returned the cycle after the strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= {~mem_addr, mem_addr};

    always @(negedge clk) begin
        if (clt_valid) begin
            got[got_n % 64] = clt_data;
            got_n = got_n + 1;
        end
        if (mem_rd) rd_n = rd_n + 1;
        if (stall) stall_n = stall_n + 1;
        if (mem_rd && !ctrl[5]) busy_bad = busy_bad + 1;
    end

    function automatic logic [DW-1:0] wexp(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_words(input int target, input int maxc);
        for (int i = 0; i < maxc && got_n < target; i++) @(negedge clk);
        #1;
    endtask

    task automatic setup(input logic [7:0] l, input logic [7:0] h, input logic [7:0] c);
        ready = 1'b0;
        wr(2'd1, l);
        wr(2'd2, h);
        wr(2'd0, c);
    endtask

    task automatic stop_all();
        ready = 1'b0; trig = 1'b0; irq = 1'b0; cpu_idle = 1'b0;
        wr(2'd0, 8'h00);
        idle_for(3);
    endtask

    task automatic t_reset();
        chk("R1", "ctrl", ctrl, 8'h00);
        chk("R1", "lo", lo, 0);
        chk("R1", "hi", hi, 0);
        chk("R1", "outputs", {mem_rd, clt_valid, stall}, 3'b000);
        wr(2'd3, 8'h55);   // R2: select 3 writes nothing
        chk("R2", "sel3 no effect", {ctrl, lo, hi}, 24'h0);
    endtask

    task automatic t_concurrent();
        int b = got_n; int r0 = rd_n; int s0 = stall_n;
        setup(8'd3, 8'd6, 8'hC0);
        chk("R2", "ctrl after go", ctrl, 8'hC0);
        ready = 1'b1;
        wait_words(b + 4, 80);
        idle_for(4);
        chk("R3", "word count", got_n - b, 4);
        for (int k = 0; k < 4; k++)
            chk("R3", "word data", got[(b + k) % 64], wexp(AW'(3 + k)));
        chk("R3", "lo advanced", lo, 7);
        chk("R4", "go self-cleared", ctrl, 8'h80);
        chk("R9", "conc stall only on reads", stall_n - s0, rd_n - r0);
        chk("R5", "busy during reads", busy_bad, 0);
        stop_all();
    endtask

    task automatic t_refuse();
        int r0 = rd_n;
        clt_en = 1'b0;
        setup(8'd3, 8'd9, 8'hC0);
        chk("R6", "refused without client enable", ctrl, 8'h90);
        clt_en = 1'b1;
        wr(2'd1, 8'd245);
        wr(2'd0, 8'hC0);
        chk("R6", "refused at unmapped lo", ctrl, 8'h90);
        wr(2'd1, 8'd3);
        wr(2'd0, 8'hC0);
        chk("R6", "accepted clears invalid", ctrl, 8'hC0);
        chk("R6", "no read while refused", rd_n - r0, 0);
        stop_all();
    endtask

    task automatic t_burst_irq();
        int b = got_n;
        irq = 1'b1;
        setup(8'd10, 8'd13, 8'hC9);
        ready = 1'b1;
        idle_for(10);
        chk("R10", "masked no words", got_n - b, 0);
        chk("R10", "stored go kept", ctrl[6], 1'b1);
        chk("R10", "no stall while masked", stall, 1'b0);
        irq = 1'b0;
        #1;
        chk("R9", "burst stall", stall, 1'b1);
        wait_words(b + 4, 80);
        idle_for(4);
        chk("R10", "resumed count", got_n - b, 4);
        chk("R10", "resumed last word", got[(b + 3) % 64], wexp(AW'(13)));
        chk("R9", "stall released", stall, 1'b0);
        stop_all();
    endtask

    task automatic t_burst_nomask();
        int b = got_n;
        irq = 1'b1;
        setup(8'd20, 8'd21, 8'hC1);
        ready = 1'b1;
        #1;
        chk("R11", "stall under irq", stall, 1'b1);
        wait_words(b + 2, 60);
        chk("R11", "irq ignored count", got_n - b, 2);
        chk("R11", "irq ignored data", got[b % 64], wexp(AW'(20)));
        stop_all();
    endtask

    task automatic t_peek();
        int b = got_n; int s0;
        irq = 1'b1;
        setup(8'd30, 8'd31, 8'hCA);
        ready = 1'b1;
        idle_for(10);
        chk("R12", "peek waits idle", got_n - b, 0);
        chk("R5", "busy with ready", ctrl[5], 1'b1);
        ready = 1'b0;
        #1;
        chk("R5", "busy drops without ready", ctrl[5], 1'b0);
        ready = 1'b1;
        s0 = stall_n;
        cpu_idle = 1'b1;
        wait_words(b + 2, 60);
        chk("R11", "peek ignores intm", got_n - b, 2);
        chk("R12", "peek data", got[(b + 1) % 64], wexp(AW'(31)));
        chk("R9", "peek no stall", stall_n - s0, 0);
        stop_all();
    endtask

    task automatic t_trig();
        int b = got_n;
        setup(8'd40, 8'd42, 8'hC3);
        ready = 1'b1;
        idle_for(10);
        chk("R12", "no trigger no word", got_n - b, 0);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        idle_for(8);
        chk("R12", "one word per pulse", got_n - b, 1);
        chk("R12", "trig data", got[b % 64], wexp(AW'(40)));
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        idle_for(8);
        chk("R12", "second pulse", got_n - b, 2);
        stop_all();
    endtask

    task automatic t_unmapped();
        int b = got_n;
        setup(8'd238, 8'd250, 8'hC0);
        ready = 1'b1;
        wait_words(b + 2, 60);
        idle_for(12);
        chk("R7", "stopped at map end", got_n - b, 2);
        chk("R7", "last word", got[(b + 1) % 64], wexp(AW'(239)));
        chk("R7", "invalid set go clear", ctrl, 8'h90);
        chk("R7", "lo value", lo, 240);
        stop_all();
    endtask

    task automatic t_disable();
        int b = got_n;
        setup(8'd50, 8'd60, 8'hC0);
        @(negedge clk); ready = 1'b1;
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h40;
        @(negedge clk); wr_en = 1'b0;
        idle_for(10);
        chk("R8", "no word after disable", got_n - b, 0);
        chk("R8", "lo kept", lo, 50);
        chk("R8", "hi kept", hi, 60);
        chk("R8", "ctrl kept", ctrl, 8'h40);
        stop_all();
    endtask

    task automatic t_collide();
        int b = got_n;
        setup(8'd70, 8'd80, 8'hC0);
        ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clt_valid) break;
        end
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'd90; ready = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R13", "write beats increment", lo, 90);
        idle_for(4);
        chk("R13", "single word", got_n - b, 1);
        chk("R13", "word data", got[b % 64], wexp(AW'(70)));
        chk("R4", "go cleared past hi", ctrl[6], 1'b0);
        stop_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_for(1);
        t_reset();
        t_concurrent();
        t_refuse();
        t_burst_irq();
        t_burst_nomask();
        t_peek();
        t_trig();
        t_disable();
        t_collide();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule